// File: doc/BRIEF.md
# Loop Battery Monitor with Debounce

This block watches the loop-current status of a telephone line interface. Once per tick it samples a 4-bit line status nibble and sorts the value into one of three classes: battery absent (all bits clear), battery present (all bits set), or ambiguous (anything else). A debounce down-counter blocks a change of the battery level until readings have been steady for a set number of ticks. The block emits single-cycle hook events when the level changes: an on-hook event when battery is lost and an off-hook event when battery returns.

A second, separate counter adds up the ticks that read "absent". When that count passes a long limit, a red alarm is raised. The alarm stays up until battery is restored. Both the raising and the clearing of the alarm give a one-cycle change-notify pulse. The reset input is asynchronous and active low. Its release is synchronised to the clock inside the block.

Top module: `batt_monitor`

## Requirements
- R1: After reset, battery_present, red_alarm and all event pulses are 0, and the debounce and loss counters are cleared.
- R2: A status nibble of 0x0 reads as absent and 0xF reads as present. Any other value reloads the debounce counter and leaves the battery level and the events unchanged.
- R3: On a tick where the nibble is 0xF, battery is absent and the debounce counter is zero, battery_present goes to 1 and offhook_evt pulses. Both are visible one clock after that tick.
- R4: While battery is present, the 80th consecutive 0x0 tick after the last reload clears battery_present and pulses onhook_evt.
- R5: After a loss, 0xF ticks count the debounce down, and battery returns on the 80th of them. A 0x0 tick while battery is absent reloads the counter.
- R6: The debounce reload value is DEB_RELOAD (80). The counter decrements once per tick while it is nonzero, so a reload restarts the full 80-tick window.
- R7: In a cycle with tick low, no output changes except that event pulses return to 0.
- R8: Every 0x0 tick increments a loss counter, which is cleared only when battery returns. On the tick where the count first exceeds LOSS_LIMIT (5000), red_alarm rises and alarm_change pulses.
- R9: When battery returns while red_alarm is set, red_alarm falls in the same cycle as offhook_evt, and alarm_change pulses.
- R10: Each event pulse lasts exactly one cycle, and onhook_evt and offhook_evt are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Sample strobe; one evaluation per high cycle |
| line_stat | input | NIB_W | Line status nibble |
| battery_present | output | 1 | Debounced battery level |
| onhook_evt | output | 1 | One-cycle pulse on battery loss |
| offhook_evt | output | 1 | One-cycle pulse on battery return |
| red_alarm | output | 1 | Long battery loss alarm |
| alarm_change | output | 1 | One-cycle pulse when red_alarm changes |

## Verification
Every output is registered, so the effect of a tick appears exactly one clock after the rising edge that samples it. The bench drives tick and the nibble at the falling edge and queues the expected outputs for that cycle. The monitor pops the queue and compares shortly after the next rising edge. Idle cycles also queue an expectation, which checks that pulses end after one cycle and that nothing moves without a tick. The window edges are checked at the exact tick where they fall: the 79th and 80th debounce ticks, and the 5000th and 5001st loss ticks.

// File: rtl/batmon_pkg.sv
package batmon_pkg;
  typedef enum logic [1:0] {
    LVL_NONE  = 2'd0,
    LVL_FULL  = 2'd1,
    LVL_MIXED = 2'd2
  } lvl_t;
endpackage

// File: rtl/batmon_classify.sv
module batmon_classify
  import batmon_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic [NIB_W-1:0] nib,
  output lvl_t             lvl
);
  always_comb begin
    if (nib == '0)      lvl = LVL_NONE;
    else if (&nib)      lvl = LVL_FULL;
    else                lvl = LVL_MIXED;
  end
endmodule

// File: rtl/batmon_debounce.sv
module batmon_debounce
  import batmon_pkg::*;
#(
  parameter int DEB_RELOAD = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  lvl_t lvl,
  output logic batt,
  output logic drop_evt,
  output logic rise_evt,
  output logic restore_now
);
  localparam int DEB_W = $clog2(DEB_RELOAD + 1);
  localparam logic [DEB_W-1:0] RELOAD = DEB_W'(DEB_RELOAD);

  logic [DEB_W-1:0] deb_q, deb_nx, deb_tmp;
  logic             batt_q, batt_nx, drop_q, drop_nx, rise_q, rise_nx;

  always_comb begin
    deb_tmp     = deb_q;
    deb_nx      = deb_q;
    batt_nx     = batt_q;
    drop_nx     = 1'b0;
    rise_nx     = 1'b0;
    restore_now = 1'b0;
    if (tick) begin
      unique case (lvl)
        LVL_NONE: begin
          if (batt_q && deb_q == '0) begin
            batt_nx = 1'b0;
            drop_nx = 1'b1;
            deb_tmp = RELOAD;
          end else if (!batt_q) begin
            deb_tmp = RELOAD;
          end
        end
        LVL_FULL: begin
          if (!batt_q && deb_q == '0) begin
            batt_nx     = 1'b1;
            rise_nx     = 1'b1;
            restore_now = 1'b1;
            deb_tmp     = RELOAD;
          end else if (batt_q) begin
            deb_tmp = RELOAD;
          end
        end
        default: deb_tmp = RELOAD;
      endcase
      deb_nx = (deb_tmp != '0) ? deb_tmp - 1'b1 : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      deb_q  <= '0;
      batt_q <= 1'b0;
      drop_q <= 1'b0;
      rise_q <= 1'b0;
    end else begin
      deb_q  <= deb_nx;
      batt_q <= batt_nx;
      drop_q <= drop_nx;
      rise_q <= rise_nx;
    end
  end

  assign batt     = batt_q;
  assign drop_evt = drop_q;
  assign rise_evt = rise_q;

  assert_onhook_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    drop_q |-> (!batt_q && $past(batt_q)));
  assert_offhook_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rise_q |-> (batt_q && !$past(batt_q)));
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(batt_q) && $stable(deb_q)));
  assert_excl_events_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(drop_q && rise_q));
  assert_deb_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    deb_q < RELOAD);
  assert_mixed_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && lvl == LVL_MIXED) |=> ($stable(batt_q) && !drop_q && !rise_q));
endmodule

// File: rtl/batmon_loss.sv
module batmon_loss #(
  parameter int LOSS_LIMIT = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic is_none,
  input  logic restore,
  output logic alarm,
  output logic alarm_chg
);
  localparam int CNT_W = $clog2(LOSS_LIMIT + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LOSS_LIMIT + 1);
  localparam logic [CNT_W-1:0] LIMIT   = CNT_W'(LOSS_LIMIT);

  logic [CNT_W-1:0] cnt_q, cnt_nx, cnt_inc;
  logic             alarm_q, alarm_nx, chg_q, chg_nx;

  always_comb begin
    cnt_inc  = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
    cnt_nx   = cnt_q;
    alarm_nx = alarm_q;
    chg_nx   = 1'b0;
    if (tick) begin
      if (is_none) begin
        cnt_nx = cnt_inc;
        if (cnt_inc > LIMIT && !alarm_q) begin
          alarm_nx = 1'b1;
          chg_nx   = 1'b1;
        end
      end else if (restore) begin
        cnt_nx = '0;
        if (alarm_q) begin
          alarm_nx = 1'b0;
          chg_nx   = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      alarm_q <= 1'b0;
      chg_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_nx;
      alarm_q <= alarm_nx;
      chg_q   <= chg_nx;
    end
  end

  assign alarm     = alarm_q;
  assign alarm_chg = chg_q;

  assert_alarm_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_q) |-> chg_q);
  assert_alarm_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alarm_q) |-> chg_q);
  assert_chg_real_R10: assert property (@(posedge clk) disable iff (!rst_n)
    chg_q |-> (alarm_q != $past(alarm_q)));
  assert_cnt_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);
endmodule

// File: rtl/batt_monitor.sv
module batt_monitor
  import batmon_pkg::*;
#(
  parameter int NIB_W      = 4,
  parameter int DEB_RELOAD = 80,
  parameter int LOSS_LIMIT = 5000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [NIB_W-1:0] line_stat,
  output logic             battery_present,
  output logic             onhook_evt,
  output logic             offhook_evt,
  output logic             red_alarm,
  output logic             alarm_change
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  lvl_t       lvl;
  logic       restore_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  batmon_classify #(.NIB_W(NIB_W)) u_class (
    .nib (line_stat),
    .lvl (lvl)
  );

  batmon_debounce #(.DEB_RELOAD(DEB_RELOAD)) u_deb (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .tick        (tick),
    .lvl         (lvl),
    .batt        (battery_present),
    .drop_evt    (onhook_evt),
    .rise_evt    (offhook_evt),
    .restore_now (restore_now)
  );

  batmon_loss #(.LOSS_LIMIT(LOSS_LIMIT)) u_loss (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .tick      (tick),
    .is_none   (lvl == LVL_NONE),
    .restore   (restore_now),
    .alarm     (red_alarm),
    .alarm_chg (alarm_change)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_int_n |=> (!battery_present && !red_alarm && !onhook_evt && !offhook_evt));
endmodule

// File: tb/batt_monitor_tb.sv
module batt_monitor_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [3:0] line_stat = 4'h0;
  logic       battery_present, onhook_evt, offhook_evt, red_alarm, alarm_change;

  int n_chk = 0;
  int n_bad = 0;
  logic [4:0] exp_q[$];
  string      tag_q[$];
  bit         done = 1'b0;

  always #10 clk = ~clk;

  batt_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .line_stat(line_stat),
    .battery_present(battery_present), .onhook_evt(onhook_evt),
    .offhook_evt(offhook_evt), .red_alarm(red_alarm), .alarm_change(alarm_change)
  );

  // expected vector: {battery_present, onhook, offhook, red_alarm, alarm_change}
  task automatic drv(input bit en, input logic [3:0] nib, input logic [4:0] ex, input string tag);
    @(negedge clk);
    tick      = en;
    line_stat = nib;
    exp_q.push_back(ex);
    tag_q.push_back(tag);
  endtask

  always begin
    @(posedge clk);
    #5;
    if (exp_q.size() > 0) begin
      logic [4:0] e;
      logic [4:0] a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {battery_present, onhook_evt, offhook_evt, red_alarm, alarm_change};
      n_chk++;
      if (a !== e) begin
        n_bad++;
        $display("FAIL %s: actual %b expected %b", t, a, e);
      end
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    n_chk++;  // R1 reset state
    if ({battery_present, onhook_evt, offhook_evt, red_alarm, alarm_change} !== 5'b0) begin
      n_bad++;
      $display("FAIL R1: actual %b expected 00000",
               {battery_present, onhook_evt, offhook_evt, red_alarm, alarm_change});
    end
    // R7: no tick, present nibble ignored
    drv(0, 4'hF, 5'b00000, "R7 idle");
    drv(0, 4'hF, 5'b00000, "R7 idle");
    // R3 first present reading with debounce at zero
    drv(1, 4'hF, 5'b10100, "R3 set");
    drv(1, 4'hF, 5'b10000, "R10 pulse ends");
    // R6 / R2: ambiguous reading restarts window
    for (int i = 0; i < 40; i++) drv(1, 4'h0, 5'b10000, "R6 early zeros");
    drv(1, 4'h5, 5'b10000, "R2 mixed holds");
    for (int i = 0; i < 79; i++) drv(1, 4'h0, 5'b10000, "R6 window restarted");
    drv(1, 4'h0, 5'b01000, "R4 loss");
    drv(0, 4'h0, 5'b00000, "R10 pulse ends");
    // R5 recovery, with a zero reload in the middle
    for (int i = 0; i < 30; i++) drv(1, 4'hF, 5'b00000, "R5 hold");
    drv(1, 4'h0, 5'b00000, "R5 zero reload");
    for (int i = 0; i < 79; i++) drv(1, 4'hF, 5'b00000, "R5 hold after reload");
    drv(1, 4'hF, 5'b10100, "R5 restore");
    // R8 long loss alarm
    for (int i = 1; i <= 5002; i++) begin
      if (i < 80)        drv(1, 4'h0, 5'b10000, "R4 debounce");
      else if (i == 80)  drv(1, 4'h0, 5'b01000, "R4 loss");
      else if (i <= 5000) drv(1, 4'h0, 5'b00000, "R8 below limit");
      else if (i == 5001) drv(1, 4'h0, 5'b00011, "R8 alarm raise");
      else               drv(1, 4'h0, 5'b00010, "R8 alarm hold");
    end
    // R9 alarm clear on restore
    for (int i = 0; i < 79; i++) drv(1, 4'hF, 5'b00010, "R9 alarm held");
    drv(1, 4'hF, 5'b10101, "R9 alarm clear");
    drv(0, 4'hF, 5'b10000, "R10 pulses end");
    drv(0, 4'h0, 5'b10000, "R7 idle zero ignored");
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule